// File: doc/BRIEF.md
# Vector Byte Table Lookup Unit

This block belongs to a SIMD datapath. It holds a register file of 32 vectors, each 128 bits wide. On a lookup command it joins one to four consecutive registers into a byte table of 16 to 64 bytes. Each byte of an index register then serves as an address into that table. The unit assembles the selected bytes into a result vector. It writes that vector back to a destination register and also presents it at its output.

Lane count follows the width bit: a narrow command fills 8 byte lanes and a wide command fills 16. Some indices fall past the end of the table. The mode bit decides what those lanes produce: a zero byte, or the byte already held in the same lane of the destination register. Between commands, a preload port fills registers directly.

Top module: `vtbl_unit`

## Requirements
- R1: With `cmd_q_i`=0 only byte lanes 0..7 (bits 63:0) are looked up and result bits 127:64 are zero. With `cmd_q_i`=1 all 16 lanes are looked up.
- R2: The table holds `cmd_len_i`+1 registers, which gives a table of 16, 32, 48 or 64 bytes.
- R3: Table register k is register number (`cmd_rn_i` + k) mod 32. A table that starts at register 30 or 31 wraps around to register 0.
- R4: Table byte b is byte (b mod 16) of table register b/16. Byte j of any register occupies bits 8j+7:8j.
- R5: Lane i reads its index from byte i of register `cmd_rm_i` as an unsigned value. The lane is in range when that index is below 16*(`cmd_len_i`+1), and an in-range lane yields table byte index.
- R6: With `cmd_keep_i`=0, every active lane whose index is out of range yields 0.
- R7: With `cmd_keep_i`=1, every active lane whose index is out of range yields the old byte of that lane of register `cmd_rd_i`. Even the old byte of the destination register is the value from before the command.
- R8: On the clock edge that samples `cmd_valid_i`=1, the unit registers the result. `res_valid_o` is high for exactly the following cycle, with `res_rd_o`=`cmd_rd_i` and `res_data_o` holding the result. Register `cmd_rd_i` takes the result on that same edge.
- R9: A command reads the register contents from before its own write. A command issued in the very next cycle sees the register the previous command wrote.
- R10: Reset (`rst_ni` low, asynchronous) clears all 32 registers, `res_valid_o` and `res_data_o`.
- R11: `wr_en_i`=1 writes `wr_data_i` into register `wr_addr_i` at the clock edge. The preload is dropped when `cmd_valid_i` is high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cmd_valid_i | input | 1 | Lookup command strobe |
| cmd_q_i | input | 1 | 0: 64-bit result, 1: 128-bit result |
| cmd_len_i | input | 2 | Table register count minus one |
| cmd_keep_i | input | 1 | 0: zero out-of-range lanes, 1: keep destination byte |
| cmd_rd_i | input | 5 | Destination register number |
| cmd_rn_i | input | 5 | First table register number |
| cmd_rm_i | input | 5 | Index register number |
| wr_en_i | input | 1 | Preload write enable |
| wr_addr_i | input | 5 | Preload register number |
| wr_data_i | input | 128 | Preload data |
| res_valid_o | output | 1 | Result and write-back pulse |
| res_rd_o | output | 5 | Register number written |
| res_data_o | output | 128 | Result vector |

## Verification
The bench aims its index patterns at the edges of the table. It places indices exactly at 16, 32, 48 and 64 and at 255. A design with an off-by-one range compare would return a real table byte at the boundary instead of zero or the kept byte. Tables that start at registers 30 and 31 expose an address adder that saturates or spills past 31, because such a design would pull bytes from the wrong register. Four further cases complete the set:
- A command whose destination is also its index or table register catches a design that reads post-write values.
- A pair of back-to-back commands catches a stale read of the register just written.
- A preload issued together with a command catches a write port that merges the two writes or corrupts either one.
- Narrow commands in keep mode catch a design that leaves the upper half unzeroed.

// File: rtl/vtbl_pkg.sv
package vtbl_pkg;
  localparam int VLEN_C = 128;
  localparam int NREG_C = 32;
  localparam int NTAB_C = 4;
endpackage

// File: rtl/vtbl_regfile.sv
module vtbl_regfile #(
  parameter int NREG = 32,
  parameter int W    = 128,
  parameter int NRD  = 6,
  localparam int AW  = $clog2(NREG)
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic [NRD-1:0][AW-1:0]   raddr_i,
  output logic [NRD-1:0][W-1:0]    rdata_o,
  input  logic                     we_i,
  input  logic [AW-1:0]            waddr_i,
  input  logic [W-1:0]             wdata_i
);
  logic [W-1:0] mem_q [NREG];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int r = 0; r < NREG; r++) mem_q[r] <= '0;
    end else if (we_i) begin
      mem_q[waddr_i] <= wdata_i;
    end
  end

  for (genvar p = 0; p < NRD; p++) begin : g_rd
    assign rdata_o[p] = mem_q[raddr_i[p]];
  end

  p_write_lands_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i |=> mem_q[$past(waddr_i)] == $past(wdata_i));
endmodule

// File: rtl/vtbl_table_gather.sv
module vtbl_table_gather #(
  parameter int NREG = 32,
  parameter int W    = 128,
  parameter int NTAB = 4,
  localparam int AW  = $clog2(NREG)
) (
  input  logic [AW-1:0]             rn_i,
  output logic [NTAB-1:0][AW-1:0]   raddr_o,
  input  logic [NTAB-1:0][W-1:0]    rdata_i,
  output logic [NTAB*W-1:0]         tbl_o
);
  // register numbers wrap through the AW-bit adder
  for (genvar k = 0; k < NTAB; k++) begin : g_tab
    assign raddr_o[k]          = rn_i + AW'(k);
    assign tbl_o[k*W +: W]     = rdata_i[k];
  end
endmodule

// File: rtl/vtbl_lane.sv
module vtbl_lane #(
  parameter int TBYTES = 64,
  parameter int BPR    = 16,
  parameter int LW     = 2,
  localparam int TIW   = $clog2(TBYTES)
) (
  input  logic [7:0]          idx_i,
  input  logic [TBYTES*8-1:0] tbl_i,
  input  logic [LW-1:0]       len_i,
  input  logic                keep_i,
  input  logic [7:0]          dst_i,
  input  logic                en_i,
  output logic [7:0]          byte_o
);
  logic [8:0] limit;
  logic       in_range;
  logic [7:0] hit;

  assign limit    = 9'((int'(len_i) + 1) * BPR);
  assign in_range = {1'b0, idx_i} < limit;
  assign hit      = tbl_i[{idx_i[TIW-1:0], 3'b000} +: 8];

  always_comb begin
    if (!en_i)         byte_o = 8'h00;
    else if (in_range) byte_o = hit;
    else if (keep_i)   byte_o = dst_i;
    else               byte_o = 8'h00;
  end
endmodule

// File: rtl/vtbl_unit.sv
module vtbl_unit
  import vtbl_pkg::*;
#(
  parameter int VLEN = VLEN_C,
  parameter int NREG = NREG_C,
  parameter int NTAB = NTAB_C,
  localparam int AW     = $clog2(NREG),
  localparam int LW     = $clog2(NTAB),
  localparam int LANES  = VLEN / 8,
  localparam int TBYTES = LANES * NTAB,
  localparam int NRD    = NTAB + 2
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            cmd_valid_i,
  input  logic            cmd_q_i,
  input  logic [LW-1:0]   cmd_len_i,
  input  logic            cmd_keep_i,
  input  logic [AW-1:0]   cmd_rd_i,
  input  logic [AW-1:0]   cmd_rn_i,
  input  logic [AW-1:0]   cmd_rm_i,
  input  logic            wr_en_i,
  input  logic [AW-1:0]   wr_addr_i,
  input  logic [VLEN-1:0] wr_data_i,
  output logic            res_valid_o,
  output logic [AW-1:0]   res_rd_o,
  output logic [VLEN-1:0] res_data_o
);
  logic [NRD-1:0][AW-1:0]   rf_raddr;
  logic [NRD-1:0][VLEN-1:0] rf_rdata;
  logic [NTAB-1:0][AW-1:0]  tab_addr;
  logic [NTAB-1:0][VLEN-1:0] tab_data;
  logic [NTAB*VLEN-1:0]     tbl;
  logic [VLEN-1:0]          idx_data, dst_data, look;
  logic                     rf_we;
  logic [AW-1:0]            rf_waddr;
  logic [VLEN-1:0]          rf_wdata;
  logic                     res_valid_q;
  logic [AW-1:0]            res_rd_q;
  logic [VLEN-1:0]          res_data_q;

  for (genvar k = 0; k < NTAB; k++) begin : g_rp
    assign rf_raddr[k] = tab_addr[k];
    assign tab_data[k] = rf_rdata[k];
  end
  assign rf_raddr[NTAB]   = cmd_rm_i;
  assign rf_raddr[NTAB+1] = cmd_rd_i;
  assign idx_data         = rf_rdata[NTAB];
  assign dst_data         = rf_rdata[NTAB+1];

  vtbl_table_gather #(.NREG(NREG), .W(VLEN), .NTAB(NTAB)) u_gather (
    .rn_i    (cmd_rn_i),
    .raddr_o (tab_addr),
    .rdata_i (tab_data),
    .tbl_o   (tbl)
  );

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    localparam bit LOW_HALF = (l < LANES / 2);
    logic lane_en;
    assign lane_en = cmd_q_i | LOW_HALF;
    vtbl_lane #(.TBYTES(TBYTES), .BPR(LANES), .LW(LW)) u_lane (
      .idx_i  (idx_data[l*8 +: 8]),
      .tbl_i  (tbl),
      .len_i  (cmd_len_i),
      .keep_i (cmd_keep_i),
      .dst_i  (dst_data[l*8 +: 8]),
      .en_i   (lane_en),
      .byte_o (look[l*8 +: 8])
    );
  end

  // lookup write-back wins over preload
  assign rf_we    = cmd_valid_i | wr_en_i;
  assign rf_waddr = cmd_valid_i ? cmd_rd_i : wr_addr_i;
  assign rf_wdata = cmd_valid_i ? look : wr_data_i;

  vtbl_regfile #(.NREG(NREG), .W(VLEN), .NRD(NRD)) u_rf (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .raddr_i (rf_raddr),
    .rdata_o (rf_rdata),
    .we_i    (rf_we),
    .waddr_i (rf_waddr),
    .wdata_i (rf_wdata)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      res_valid_q <= 1'b0;
      res_rd_q    <= '0;
      res_data_q  <= '0;
    end else begin
      res_valid_q <= cmd_valid_i;
      if (cmd_valid_i) begin
        res_rd_q   <= cmd_rd_i;
        res_data_q <= look;
      end
    end
  end

  assign res_valid_o = res_valid_q;
  assign res_rd_o    = res_rd_q;
  assign res_data_o  = res_data_q;

  p_pulse_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_valid_i |=> res_valid_o);
  p_no_pulse_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cmd_valid_i |=> !res_valid_o);
  p_dest_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_valid_i |=> res_rd_o == $past(cmd_rd_i));
  p_upper_zero_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_valid_i && !cmd_q_i |=> res_data_o[VLEN-1:VLEN/2] == '0);
  p_oor_zero_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_valid_i && !cmd_keep_i && idx_data[7:6] != 2'b00 |=> res_data_o[7:0] == 8'h00);
  p_oor_keep_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_valid_i && cmd_keep_i && idx_data[7:6] != 2'b00 |=> res_data_o[7:0] == $past(dst_data[7:0]));
  p_wb_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    res_valid_o && !cmd_valid_i && cmd_rm_i == res_rd_o |-> idx_data == res_data_o);
endmodule

// File: tb/vtbl_unit_tb.sv
module vtbl_unit_tb_top;
  typedef struct packed {
    logic       q;
    logic [1:0] len;
    logic       keep;
    logic [4:0] rd;
    logic [4:0] rn;
    logic [4:0] rm;
  } vec_t;

  localparam int NV = 13;
  localparam vec_t VECS [NV] = '{
    '{1'b1, 2'd0, 1'b0, 5'd1,  5'd3,  5'd20},
    '{1'b1, 2'd1, 1'b0, 5'd2,  5'd4,  5'd20},
    '{1'b1, 2'd2, 1'b0, 5'd5,  5'd6,  5'd20},
    '{1'b1, 2'd3, 1'b0, 5'd7,  5'd8,  5'd20},
    '{1'b1, 2'd3, 1'b1, 5'd9,  5'd10, 5'd20},
    '{1'b0, 2'd1, 1'b0, 5'd11, 5'd12, 5'd20},
    '{1'b0, 2'd1, 1'b1, 5'd13, 5'd14, 5'd20},
    '{1'b1, 2'd3, 1'b0, 5'd15, 5'd30, 5'd22},
    '{1'b1, 2'd2, 1'b1, 5'd16, 5'd31, 5'd22},
    '{1'b1, 2'd0, 1'b1, 5'd17, 5'd17, 5'd20},
    '{1'b1, 2'd3, 1'b0, 5'd18, 5'd18, 5'd22},
    '{1'b0, 2'd3, 1'b1, 5'd19, 5'd29, 5'd22},
    '{1'b1, 2'd0, 1'b1, 5'd20, 5'd5,  5'd20}
  };

  logic         clk_i = 1'b0;
  logic         rst_ni = 1'b0;
  logic         cmd_valid_i = 1'b0, cmd_q_i = 1'b0, cmd_keep_i = 1'b0;
  logic [1:0]   cmd_len_i = '0;
  logic [4:0]   cmd_rd_i = '0, cmd_rn_i = '0, cmd_rm_i = '0;
  logic         wr_en_i = 1'b0;
  logic [4:0]   wr_addr_i = '0;
  logic [127:0] wr_data_i = '0;
  logic         res_valid_o;
  logic [4:0]   res_rd_o;
  logic [127:0] res_data_o;

  logic [127:0] mdl [32];
  int n_cmp = 0, n_bad = 0;
  bit done = 0;

  always #10 clk_i = ~clk_i;

  vtbl_unit dut_i (.*);

  task automatic report();
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  task automatic chk(string tag, logic [127:0] act, logic [127:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [127:0] ref_lookup(vec_t v);
    logic [127:0] r = '0;
    for (int l = 0; l < 16; l++) begin
      int idx = int'(mdl[v.rm][l*8 +: 8]);
      if (!v.q && l >= 8) r[l*8 +: 8] = 8'h00;
      else if (idx < 16 * (int'(v.len) + 1))
        r[l*8 +: 8] = mdl[(int'(v.rn) + idx / 16) % 32][(idx % 16) * 8 +: 8];
      else if (v.keep) r[l*8 +: 8] = mdl[v.rd][l*8 +: 8];
      else r[l*8 +: 8] = 8'h00;
    end
    return r;
  endfunction

  task automatic drive(vec_t v);
    cmd_valid_i = 1'b1; cmd_q_i = v.q; cmd_len_i = v.len; cmd_keep_i = v.keep;
    cmd_rd_i = v.rd; cmd_rn_i = v.rn; cmd_rm_i = v.rm;
  endtask

  task automatic check_res(vec_t v, logic [127:0] exp, string tag);
    chk("R8 valid", 128'(res_valid_o), 128'd1);
    chk("R8 dest", 128'(res_rd_o), 128'(v.rd));
    chk(tag, res_data_o, exp);
  endtask

  task automatic run_cmd(vec_t v, string tag);
    logic [127:0] exp = ref_lookup(v);
    @(negedge clk_i); drive(v);
    @(negedge clk_i); cmd_valid_i = 1'b0;
    check_res(v, exp, tag);
    mdl[v.rd] = exp;
  endtask

  task automatic preload(int a, logic [127:0] d);
    @(negedge clk_i); wr_en_i = 1'b1; wr_addr_i = 5'(a); wr_data_i = d;
    @(negedge clk_i); wr_en_i = 1'b0;
    mdl[a] = d;
  endtask

  initial begin
    repeat (20000) @(posedge clk_i);
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    report();
  end

  initial begin
    logic [127:0] d;
    vec_t va, vb;
    logic [127:0] ea, eb;
    for (int r = 0; r < 32; r++) mdl[r] = '0;
    repeat (3) @(negedge clk_i);
    chk("R10 valid in reset", 128'(res_valid_o), 128'd0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk("R10 valid after reset", 128'(res_valid_o), 128'd0);
    chk("R10 data after reset", res_data_o, 128'd0);

    // R11 preload: general pattern, then index registers 20..22
    for (int r = 0; r < 32; r++) begin
      for (int j = 0; j < 16; j++) d[j*8 +: 8] = 8'(r * 37 + j * 11 + 1);
      preload(r, d);
    end
    d = {8'd1, 8'd49, 8'd32, 8'd16, 8'd31, 8'd15, 8'd255, 8'd200,
         8'd64, 8'd63, 8'd48, 8'd47, 8'd33, 8'd17, 8'd5, 8'd0};
    preload(20, d);
    for (int j = 0; j < 16; j++) d[j*8 +: 8] = 8'(j);
    preload(21, d);
    for (int j = 0; j < 16; j++) d[j*8 +: 8] = 8'(j * 4 + 3);
    preload(22, d);

    // vector table: R1 R2 R3 R4 R5 plus R6 or R7
    for (int i = 0; i < NV; i++)
      run_cmd(VECS[i], $sformatf("R1 R2 R3 R4 R5 %s vec %0d",
                                 VECS[i].keep ? "R7" : "R6", i));

    // R9 back-to-back: B reads register A just wrote
    va = '{1'b1, 2'd0, 1'b0, 5'd23, 5'd3, 5'd21};
    vb = '{1'b1, 2'd0, 1'b0, 5'd24, 5'd23, 5'd21};
    ea = ref_lookup(va);
    @(negedge clk_i); drive(va);
    mdl[va.rd] = ea;
    eb = ref_lookup(vb);
    @(negedge clk_i); drive(vb);
    check_res(va, ea, "R9 first");
    @(negedge clk_i); cmd_valid_i = 1'b0;
    check_res(vb, eb, "R9 second");
    mdl[vb.rd] = eb;

    // R11 preload dropped when a command is in the same cycle
    va = '{1'b1, 2'd0, 1'b0, 5'd25, 5'd4, 5'd21};
    ea = ref_lookup(va);
    @(negedge clk_i); drive(va);
    wr_en_i = 1'b1; wr_addr_i = 5'd26; wr_data_i = {4{32'hdeadbeef}};
    @(negedge clk_i); cmd_valid_i = 1'b0; wr_en_i = 1'b0;
    check_res(va, ea, "R11 cmd beside preload");
    mdl[va.rd] = ea;
    run_cmd('{1'b1, 2'd0, 1'b0, 5'd28, 5'd26, 5'd21}, "R11 dropped preload");
    preload(26, {4{32'h0badf00d}});
    run_cmd('{1'b1, 2'd0, 1'b0, 5'd28, 5'd26, 5'd21}, "R11 preload lands");

    // R10 mid-run reset clears registers
    @(negedge clk_i); rst_ni = 1'b0;
    @(negedge clk_i); rst_ni = 1'b1;
    for (int r = 0; r < 32; r++) mdl[r] = '0;
    chk("R10 valid after mid reset", 128'(res_valid_o), 128'd0);
    chk("R10 data after mid reset", res_data_o, 128'd0);
    run_cmd('{1'b1, 2'd3, 1'b1, 5'd27, 5'd3, 5'd21}, "R10 cleared registers");
    @(negedge clk_i);
    chk("R8 pulse ends", 128'(res_valid_o), 128'd0);
    report();
  end
endmodule